// File: doc/BRIEF.md
# Three-Dimensional DMA Address Generator

This block turns a transfer record into a stream of address and length beats. A transfer is a block of frames, a frame is a run of arrays, and an array is a run of contiguous bytes. The caller supplies the record in one cycle: the options word, the source and destination start addresses, the three counts, signed 16-bit strides between arrays and between frames (one pair for each direction), and a reload value for the array count. The block then waits for synchronization events. Each beat it emits names one array: where it is read from, where it is written to, and how many bytes it holds.

Two granularities are supported. In array-synchronized mode every event releases a single array. The array count is refilled from the reload field at the end of each frame. In frame-synchronized mode one event releases a whole frame, as back-to-back beats on consecutive cycles. Either address can be pinned to a constant for a fixed-location peripheral FIFO, with an access-width code carried alongside. On the last array of the block an optional completion pulse carries a short code. The generator then goes idle until it is loaded again.

Top module: `dma3d_addr_gen`

## Requirements
- R1: A load pulse captures the record; `busy` is high from the next cycle, and every beat reports `beatLen` equal to the loaded array count.
- R2: In array-synchronized mode (option bit 2 low), an event seen while busy and waiting gives exactly one beat, registered one cycle later. Within a frame, each address is the previous array's address plus its signed array stride.
- R3: In array-synchronized mode, the first array of a new frame sits at the last array of the previous frame plus the signed frame stride. Frames after the first hold as many arrays as the reload field says.
- R4: In frame-synchronized mode (option bit 2 high), one event gives as many beats as the frame count, on consecutive cycles starting one cycle after the event. Events that arrive during such a burst are ignored.
- R5: In frame-synchronized mode, each frame starts at the previous frame's start plus the signed frame stride, and every frame holds the loaded frame count of arrays.
- R6: Option bit 0 holds the source address, and option bit 1 holds the destination address, at their start values for the whole transfer. `beatWidth` always reports option bits [10:8].
- R7: When option bit 3 is set, `doneValid` pulses in the same cycle as the final beat of the block, and `doneCode` equals option bits [7:4]. When bit 3 is clear, no pulse is given.
- R8: After the final beat, `busy` is low and the completion pulse is not repeated.
- R9: An event while not busy (before any load, or after the block has finished) produces no beat and no completion.
- R10: After reset `busy`, `beatValid` and `doneValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| loadIn | input | 1 | Capture the record and start a transfer |
| optIn | input | 11 | Options: [0] source constant, [1] destination constant, [2] frame sync, [3] completion enable, [7:4] completion code, [10:8] access width |
| srcIn | input | ADDR_W | Source start address |
| dstIn | input | ADDR_W | Destination start address |
| aCntIn | input | CNT_W | Bytes per array (at least 1) |
| bCntIn | input | CNT_W | Arrays per frame (at least 1) |
| cCntIn | input | CNT_W | Frames per block (at least 1) |
| srcBIdxIn | input | IDX_W | Signed source stride between arrays |
| dstBIdxIn | input | IDX_W | Signed destination stride between arrays |
| srcCIdxIn | input | IDX_W | Signed source stride between frames |
| dstCIdxIn | input | IDX_W | Signed destination stride between frames |
| bReloadIn | input | CNT_W | Array-count reload for array-synchronized mode (at least 1) |
| syncEvent | input | 1 | Synchronization event |
| busy | output | 1 | Transfer loaded and not finished |
| beatValid | output | 1 | Beat fields are valid this cycle |
| beatSrc | output | ADDR_W | Source address of the array |
| beatDst | output | ADDR_W | Destination address of the array |
| beatLen | output | CNT_W | Byte length of the array |
| beatWidth | output | 3 | Access width code |
| doneValid | output | 1 | Completion pulse |
| doneCode | output | 4 | Completion code |

## Verification
The bench sweeps both sync modes over frame counts of one to three, block counts of one to three, and two reload values. Each point is tried with positive strides and with negative strides. Single-array frames and single-frame blocks exercise the cases where the frame step and the block end coincide with the first array. A reload value different from the frame count separates the first frame from later frames in array-synchronized mode. Negative strides show that the strides are sign-extended. The four constant-address combinations, the completion enable and the code rotate across the sweep. A second event injected in the middle of a burst, and events after completion, show that stray events are dropped.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;

  localparam int OPT_W          = 11;
  localparam int OPT_SRC_CONST  = 0;
  localparam int OPT_DST_CONST  = 1;
  localparam int OPT_FRAME_SYNC = 2;
  localparam int OPT_DONE_EN    = 3;
  localparam int OPT_CODE_LSB   = 4;
  localparam int CODE_W         = 4;
  localparam int OPT_WID_LSB    = 8;
  localparam int WID_W          = 3;
  localparam int LANES          = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2
  } seqState_t;

  typedef struct packed {
    logic load;
    logic emit;
    logic advArray;
    logic advFrame;
    logic finish;
  } ctrlStrobe_t;

endpackage

// File: rtl/dma3d_ctrl.sv
module dma3d_ctrl
  import dma3d_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadIn,
  input  logic        syncEvent,
  input  logic        lastArray,
  input  logic        lastFrame,
  input  logic        frameSync,
  output ctrlStrobe_t strobe,
  output logic        busy
);

  seqState_t state, nextState;
  logic      emitNow;

  always_comb begin
    strobe    = '0;
    nextState = state;
    emitNow   = 1'b0;
    strobe.load = loadIn;
    if (loadIn) begin
      nextState = ST_WAIT;
    end else begin
      emitNow = ((state == ST_WAIT) && syncEvent) || (state == ST_BURST);
      strobe.emit     = emitNow;
      strobe.advArray = emitNow && !lastArray;
      strobe.advFrame = emitNow && lastArray;
      strobe.finish   = emitNow && lastArray && lastFrame;
      if (emitNow) begin
        if (lastArray)
          nextState = lastFrame ? ST_IDLE : ST_WAIT;
        else if (frameSync)
          nextState = ST_BURST;
        else
          nextState = ST_WAIT;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/dma3d_lane.sv
module dma3d_lane
  import dma3d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              frameSync,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [IDX_W-1:0]  bIdxIn,
  input  logic [IDX_W-1:0]  cIdxIn,
  input  logic              constIn,
  output logic [ADDR_W-1:0] addr
);

  localparam int EXT_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] curAddr, frmAddr, arrayStep, frameStep, frameBase;
  logic [IDX_W-1:0]  bIdxR, cIdxR;
  logic              constR;

  always_comb begin
    frameBase = frameSync ? frmAddr : curAddr;
    arrayStep = curAddr + {{EXT_W{bIdxR[IDX_W-1]}}, bIdxR};
    frameStep = frameBase + {{EXT_W{cIdxR[IDX_W-1]}}, cIdxR};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      frmAddr <= '0;
      bIdxR   <= '0;
      cIdxR   <= '0;
      constR  <= 1'b0;
    end else if (strobe.load) begin
      curAddr <= baseIn;
      frmAddr <= baseIn;
      bIdxR   <= bIdxIn;
      cIdxR   <= cIdxIn;
      constR  <= constIn;
    end else if (!constR) begin
      if (strobe.advFrame) begin
        curAddr <= frameStep;
        frmAddr <= frameStep;
      end else if (strobe.advArray) begin
        curAddr <= arrayStep;
      end
    end
  end

  assign addr = curAddr;

endmodule

// File: rtl/dma3d_path.sv
module dma3d_path
  import dma3d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [OPT_W-1:0]  optIn,
  input  logic [ADDR_W-1:0] srcIn,
  input  logic [ADDR_W-1:0] dstIn,
  input  logic [CNT_W-1:0]  aCntIn,
  input  logic [CNT_W-1:0]  bCntIn,
  input  logic [CNT_W-1:0]  cCntIn,
  input  logic [IDX_W-1:0]  srcBIdxIn,
  input  logic [IDX_W-1:0]  dstBIdxIn,
  input  logic [IDX_W-1:0]  srcCIdxIn,
  input  logic [IDX_W-1:0]  dstCIdxIn,
  input  logic [CNT_W-1:0]  bReloadIn,
  output logic              lastArray,
  output logic              lastFrame,
  output logic              frameSync,
  output logic              beatValid,
  output logic [ADDR_W-1:0] beatSrc,
  output logic [ADDR_W-1:0] beatDst,
  output logic [CNT_W-1:0]  beatLen,
  output logic [WID_W-1:0]  beatWidth,
  output logic              doneValid,
  output logic [CODE_W-1:0] doneCode
);

  logic [OPT_W-1:0] optR;
  logic [CNT_W-1:0] aCntR, bCntR, bReloadR, bRem, cRem;

  logic [LANES-1:0][ADDR_W-1:0] laneBase, laneAddr;
  logic [LANES-1:0][IDX_W-1:0]  laneBIdx, laneCIdx;
  logic [LANES-1:0]             laneConst;

  assign laneBase  = {dstIn, srcIn};
  assign laneBIdx  = {dstBIdxIn, srcBIdxIn};
  assign laneCIdx  = {dstCIdxIn, srcCIdxIn};
  assign laneConst = {optIn[OPT_DST_CONST], optIn[OPT_SRC_CONST]};
  assign frameSync = optR[OPT_FRAME_SYNC];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    dma3d_lane #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) uLane (
      .clk       (clk),
      .rstN      (rstN),
      .strobe    (strobe),
      .frameSync (frameSync),
      .baseIn    (laneBase[g]),
      .bIdxIn    (laneBIdx[g]),
      .cIdxIn    (laneCIdx[g]),
      .constIn   (laneConst[g]),
      .addr      (laneAddr[g])
    );
  end

  assign lastArray = (bRem == CNT_W'(1));
  assign lastFrame = (cRem == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      optR     <= '0;
      aCntR    <= '0;
      bCntR    <= '0;
      bReloadR <= '0;
      bRem     <= '0;
      cRem     <= '0;
    end else if (strobe.load) begin
      optR     <= optIn;
      aCntR    <= aCntIn;
      bCntR    <= bCntIn;
      bReloadR <= bReloadIn;
      bRem     <= bCntIn;
      cRem     <= cCntIn;
    end else if (strobe.advFrame) begin
      bRem <= frameSync ? bCntR : bReloadR;
      cRem <= cRem - CNT_W'(1);
    end else if (strobe.advArray) begin
      bRem <= bRem - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatValid <= 1'b0;
      beatSrc   <= '0;
      beatDst   <= '0;
      beatLen   <= '0;
      beatWidth <= '0;
      doneValid <= 1'b0;
      doneCode  <= '0;
    end else begin
      beatValid <= strobe.emit;
      doneValid <= strobe.finish && optR[OPT_DONE_EN];
      if (strobe.emit) begin
        beatSrc   <= laneAddr[0];
        beatDst   <= laneAddr[1];
        beatLen   <= aCntR;
        beatWidth <= optR[OPT_WID_LSB +: WID_W];
      end
      if (strobe.finish)
        doneCode <= optR[OPT_CODE_LSB +: CODE_W];
    end
  end

endmodule

// File: rtl/dma3d_addr_gen.sv
module dma3d_addr_gen
  import dma3d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadIn,
  input  logic [10:0]       optIn,
  input  logic [ADDR_W-1:0] srcIn,
  input  logic [ADDR_W-1:0] dstIn,
  input  logic [CNT_W-1:0]  aCntIn,
  input  logic [CNT_W-1:0]  bCntIn,
  input  logic [CNT_W-1:0]  cCntIn,
  input  logic [IDX_W-1:0]  srcBIdxIn,
  input  logic [IDX_W-1:0]  dstBIdxIn,
  input  logic [IDX_W-1:0]  srcCIdxIn,
  input  logic [IDX_W-1:0]  dstCIdxIn,
  input  logic [CNT_W-1:0]  bReloadIn,
  input  logic              syncEvent,
  output logic              busy,
  output logic              beatValid,
  output logic [ADDR_W-1:0] beatSrc,
  output logic [ADDR_W-1:0] beatDst,
  output logic [CNT_W-1:0]  beatLen,
  output logic [2:0]        beatWidth,
  output logic              doneValid,
  output logic [3:0]        doneCode
);

  ctrlStrobe_t strobe;
  logic        lastArray, lastFrame, frameSync;

  dma3d_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadIn    (loadIn),
    .syncEvent (syncEvent),
    .lastArray (lastArray),
    .lastFrame (lastFrame),
    .frameSync (frameSync),
    .strobe    (strobe),
    .busy      (busy)
  );

  dma3d_path #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .optIn     (optIn),
    .srcIn     (srcIn),
    .dstIn     (dstIn),
    .aCntIn    (aCntIn),
    .bCntIn    (bCntIn),
    .cCntIn    (cCntIn),
    .srcBIdxIn (srcBIdxIn),
    .dstBIdxIn (dstBIdxIn),
    .srcCIdxIn (srcCIdxIn),
    .dstCIdxIn (dstCIdxIn),
    .bReloadIn (bReloadIn),
    .lastArray (lastArray),
    .lastFrame (lastFrame),
    .frameSync (frameSync),
    .beatValid (beatValid),
    .beatSrc   (beatSrc),
    .beatDst   (beatDst),
    .beatLen   (beatLen),
    .beatWidth (beatWidth),
    .doneValid (doneValid),
    .doneCode  (doneCode)
  );

endmodule

// File: rtl/dma3d_addr_gen_chk.sv
module dma3d_addr_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             beatValid,
  input logic [CNT_W-1:0] beatLen,
  input logic [2:0]       beatWidth,
  input logic             doneValid
);

  AST_BEAT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> $past(busy)); // R9

  AST_DONE_ON_LAST_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> beatValid); // R7

  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !busy); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R8

  AST_LEN_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && $past(beatValid)) |-> $stable(beatLen)); // R1

  AST_WIDTH_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && $past(beatValid)) |-> $stable(beatWidth)); // R6

endmodule

bind dma3d_addr_gen dma3d_addr_gen_chk #(.CNT_W(CNT_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .beatValid (beatValid),
  .beatLen   (beatLen),
  .beatWidth (beatWidth),
  .doneValid (doneValid)
);

// File: tb/sim_dma3d_addr_gen.sv
`timescale 1ns/1ps
module sim_dma3d_addr_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadIn = 1'b0;
  logic [10:0] optIn = '0;
  logic [31:0] srcIn = '0, dstIn = '0;
  logic [15:0] aCntIn = '0, bCntIn = '0, cCntIn = '0, bReloadIn = '0;
  logic [15:0] srcBIdxIn = '0, dstBIdxIn = '0, srcCIdxIn = '0, dstCIdxIn = '0;
  logic        syncEvent = 1'b0;
  logic        busy, beatValid, doneValid;
  logic [31:0] beatSrc, beatDst;
  logic [15:0] beatLen;
  logic [2:0]  beatWidth;
  logic [3:0]  doneCode;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma3d_addr_gen u0 (
    .clk(clk), .rstN(rstN), .loadIn(loadIn), .optIn(optIn),
    .srcIn(srcIn), .dstIn(dstIn), .aCntIn(aCntIn), .bCntIn(bCntIn),
    .cCntIn(cCntIn), .srcBIdxIn(srcBIdxIn), .dstBIdxIn(dstBIdxIn),
    .srcCIdxIn(srcCIdxIn), .dstCIdxIn(dstCIdxIn), .bReloadIn(bReloadIn),
    .syncEvent(syncEvent), .busy(busy), .beatValid(beatValid),
    .beatSrc(beatSrc), .beatDst(beatDst), .beatLen(beatLen),
    .beatWidth(beatWidth), .doneValid(doneValid), .doneCode(doneCode)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Closed-form address of array j in frame f.
  function automatic logic [31:0] expAddr(logic [31:0] base, int bi, int ci,
      bit frameMode, bit pinned, int f, int j, int nFirst, int nReload);
    if (pinned) return base;
    if (frameMode) return base + f * ci + j * bi;
    if (f == 0) return base + j * bi;
    return base + f * ci + ((nFirst - 1) + (f - 1) * (nReload - 1) + j) * bi;
  endfunction

  task automatic checkBeat(string req, logic [31:0] s, logic [31:0] d,
      int len, int wid, bit expDone, int code);
    check(req, {31'd0, beatValid}, 32'd1);
    check(req, beatSrc, s);
    check(req, beatDst, d);
    check("R1", {16'd0, beatLen}, len);
    check("R6", {29'd0, beatWidth}, wid);
    check("R7", {31'd0, doneValid}, {31'd0, expDone});
    if (expDone) check("R7", {28'd0, doneCode}, code);
  endtask

  task automatic runCase(int n, bit frameMode, int nB, int nC, int rl, bit neg);
    logic [31:0] s0, d0;
    int aC, biS, biD, ciS, ciD, wid, code;
    bit sPin, dPin, dEn;
    s0 = 32'h1000_0000 + n * 32'h100;
    d0 = 32'h8000_0000 - n * 32'h40;
    aC = 4 + n;
    biS = neg ? -64 : 48;   biD = neg ? -16 : 32;
    ciS = neg ? -768 : 1024; ciD = neg ? 300 : -200;
    sPin = (n % 4) == 1 || (n % 4) == 3;
    dPin = (n % 4) == 2 || (n % 4) == 3;
    dEn  = (n % 3) != 0;
    wid  = n % 8;
    code = n % 16;
    @(negedge clk);
    loadIn = 1'b1;
    optIn = {wid[2:0], code[3:0], dEn, frameMode, dPin, sPin};
    srcIn = s0; dstIn = d0; aCntIn = aC[15:0];
    bCntIn = nB[15:0]; cCntIn = nC[15:0]; bReloadIn = rl[15:0];
    srcBIdxIn = biS[15:0]; dstBIdxIn = biD[15:0];
    srcCIdxIn = ciS[15:0]; dstCIdxIn = ciD[15:0];
    @(negedge clk);
    loadIn = 1'b0;
    check("R1", {31'd0, busy}, 32'd1);
    for (int f = 0; f < nC; f++) begin
      int nArr;
      nArr = (frameMode || f == 0) ? nB : rl;
      syncEvent = 1'b1;
      for (int j = 0; j < nArr; j++) begin
        bit last;
        @(negedge clk);
        // mid-burst stray event must be ignored (R4)
        syncEvent = frameMode && j == 0 && nArr >= 3;
        if (!frameMode) syncEvent = 1'b0;
        last = (f == nC - 1) && (j == nArr - 1);
        checkBeat(frameMode ? (f > 0 ? "R5" : "R4") : (f > 0 ? "R3" : "R2"),
          expAddr(s0, biS, ciS, frameMode, sPin, f, j, nB, rl),
          expAddr(d0, biD, ciD, frameMode, dPin, f, j, nB, rl),
          aC, wid, last && dEn, code);
        if (!frameMode && j != nArr - 1) begin
          @(negedge clk);
          check("R2", {31'd0, beatValid}, 32'd0);
          syncEvent = 1'b1;
        end
      end
      syncEvent = 1'b0;
      @(negedge clk);
      check(frameMode ? "R4" : "R2", {31'd0, beatValid}, 32'd0);
    end
    check("R8", {31'd0, busy}, 32'd0);
    syncEvent = 1'b1;
    @(negedge clk);
    syncEvent = 1'b0;
    @(negedge clk);
    check("R9", {31'd0, beatValid}, 32'd0);
    check("R8", {31'd0, doneValid}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int n;
    n = 0;
    repeat (3) @(negedge clk);
    check("R10", {31'd0, busy}, 32'd0);
    check("R10", {31'd0, beatValid}, 32'd0);
    check("R10", {31'd0, doneValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    syncEvent = 1'b1;
    @(negedge clk);
    syncEvent = 1'b0;
    @(negedge clk);
    check("R9", {31'd0, beatValid}, 32'd0);
    for (int m = 0; m < 2; m++)
      for (int b = 1; b <= 3; b++)
        for (int c = 1; c <= 3; c++)
          for (int r = 1; r <= 2; r++)
            for (int g = 0; g < 2; g++) begin
              runCase(n, m[0], b, c, r, g[0]);
              n++;
            end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule